// File: doc/BRIEF.md
# Barrett Modular Multiplier

This block computes the modular product (A times B) mod M of two unsigned W-bit operands. It avoids a divider by using Barrett reduction. The caller supplies, with every operand set, a W+1-bit reciprocal of the modulus: floor(4^W / M), clipped to the largest value that fits in W+1 bits. The block multiplies A by B and takes a quotient estimate from the top bits of the product and the reciprocal. It subtracts the estimate times M from the product, then applies up to two conditional subtractions of M so the remainder falls in [0, M-1].

The modulus must have its top bit set, which means M lies in [2^(W-1), 2^W - 1]. For W=8 that is 128 through 255. Setting the parameter `CONST_MOD` replaces the modulus and reciprocal ports with the parameter `MOD_VAL`. The reciprocal is then derived during elaboration. The block is a four-stage pipeline that accepts a new operand set on every enabled cycle. A valid flag travels alongside the data, and dropping the enable freezes every stage.

Top module: `barrett_modmul`

## Requirements
- R1: For A, B < M with M in [2^(W-1), 2^W-1] and R = min(floor(4^W/M), 2^(W+1)-1), `result` equals (A*B) mod M when the matching `out_valid` is high.
- R2: Whenever `out_valid` is high, `result` is strictly below the modulus that was used for that operand set.
- R3: When `en` has been high for four consecutive rising edges, `out_valid` equals the `in_valid` sampled four edges earlier. An operand set taken at edge t appears on the outputs right after edge t+3.
- R4: A rising edge with `en` low changes neither `result` nor `out_valid`. Operands presented while `en` is low are not accepted.
- R5: When `rst` is high at a rising edge, `out_valid` is 0 after that edge.
- R6: With `CONST_MOD`=1, the `m` and `r_in` ports are ignored and the modulus is `MOD_VAL`. This includes `MOD_VAL`=2^(W-1), whose reciprocal clips to 2^(W+1)-1.
- R7: Operand sets issued on back-to-back enabled cycles each produce their own result, in issue order, one per cycle.
- R8: Moduli at both ends of the legal range (2^(W-1) and 2^W-1) give correct results, including the operand corners 0 and M-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the valid pipeline |
| en | input | 1 | Advances all pipeline stages when high |
| in_valid | input | 1 | Marks the operands on this cycle as an operand set |
| a | input | W | Multiplicand, unsigned |
| b | input | W | Multiplier, unsigned |
| m | input | W | Modulus, top bit must be 1 (unused when CONST_MOD=1) |
| r_in | input | W+1 | Clipped reciprocal floor(4^W/M) (unused when CONST_MOD=1) |
| out_valid | output | 1 | Result on `result` belongs to an operand set |
| result | output | W | (A*B) mod M |

## Verification
Four properties are checked on every cycle. The output stays below the modulus carried down the pipeline. The output holds while `en` is low. The valid flag appears exactly four enabled edges after its input. In constant mode, the modulus in flight always equals the parameter. The arithmetic itself can only be shown by the bench's scenarios: exact residues against a reference remainder, back-to-back streams, stalls injected mid-stream, the clipped reciprocal at the bottom of the range, and the port-ignoring constant instance.

// File: rtl/barrett_modmul.sv
module barrett_modmul #(
  parameter int W = 8,
  parameter bit CONST_MOD = 1'b0,
  parameter int unsigned MOD_VAL = 251
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         in_valid,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] m,
  input  logic [W:0]   r_in,
  output logic         out_valid,
  output logic [W-1:0] result
);
  localparam int PW = 2 * W;
  localparam logic [PW:0] FOUR_W  = {1'b1, {PW{1'b0}}};
  localparam logic [PW:0] MOD_EXT = (PW+1)'(MOD_VAL);
  localparam logic [PW:0] R_RAW   = FOUR_W / MOD_EXT;
  localparam logic [W:0]  R_CONST = ((R_RAW >> (W+1)) != '0) ? '1 : R_RAW[W:0];

  logic [W-1:0] m_use;
  logic [W:0]   r_use;
  assign m_use = CONST_MOD ? MOD_EXT[W-1:0] : m;
  assign r_use = CONST_MOD ? R_CONST : r_in;

  // stage 1: full product
  logic          v1;
  logic [PW-1:0] p1;
  logic [W-1:0]  m1;
  logic [W:0]    r1;
  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else if (en) v1 <= in_valid;
    if (en) begin
      p1 <= PW'(a) * PW'(b);
      m1 <= m_use;
      r1 <= r_use;
    end
  end

  // stage 2: quotient estimate
  logic [PW+1:0] qprod;
  assign qprod = (PW+2)'(p1[PW-1:W-1]) * (PW+2)'(r1);

  logic          v2;
  logic [PW-1:0] p2;
  logic [W-1:0]  m2;
  logic [W:0]    q2;
  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else if (en) v2 <= v1;
    if (en) begin
      p2 <= p1;
      m2 <= m1;
      q2 <= qprod[PW+1:W+1];
    end
  end

  // stage 3: partial remainder, below 3M so W+2 bits suffice
  logic [W+1:0] qm;
  assign qm = (W+2)'(q2) * (W+2)'(m2);

  logic         v3;
  logic [W+1:0] rem3;
  logic [W-1:0] m3;
  always_ff @(posedge clk) begin
    if (rst) v3 <= 1'b0;
    else if (en) v3 <= v2;
    if (en) begin
      rem3 <= p2[W+1:0] - qm;
      m3   <= m2;
    end
  end

  // stage 4: two conditional corrections
  logic [W+1:0] mx, c1, c2;
  assign mx = {2'b00, m3};
  assign c1 = (rem3 >= mx) ? rem3 - mx : rem3;
  assign c2 = (c1 >= mx) ? c1 - mx : c1;

  logic [W-1:0] m4;
  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (en) out_valid <= v3;
    if (en) begin
      result <= c2[W-1:0];
      m4     <= m3;
    end
  end
endmodule

// File: rtl/barrett_modmul_chk.sv
module barrett_modmul_chk #(
  parameter int W = 8,
  parameter bit CONST_MOD = 1'b0,
  parameter int unsigned MOD_VAL = 251
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         in_valid,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic [W-1:0] m_q
);
  logic [2:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else if (!en) run_cnt <= '0;
    else if (run_cnt != 3'd4) run_cnt <= run_cnt + 3'd1;
  end

  AST_RES_BELOW_MOD: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (result < m_q)); // R2
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(result) && $stable(out_valid))); // R4
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == 3'd4) |-> (out_valid == $past(in_valid, 4))); // R3
  AST_CONST_MODULUS: assert property (@(posedge clk) disable iff (rst)
    (CONST_MOD && out_valid) |-> (m_q == W'(MOD_VAL))); // R6
endmodule

bind barrett_modmul barrett_modmul_chk #(.W(W), .CONST_MOD(CONST_MOD), .MOD_VAL(MOD_VAL)) u_chk (
  .clk(clk), .rst(rst), .en(en), .in_valid(in_valid),
  .out_valid(out_valid), .result(result), .m_q(m4)
);

// File: tb/sim_barrett_modmul.sv
module sim_barrett_modmul;
  localparam int W = 8;
  localparam time CLK = 4ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] a = '0, b = '0, m = 8'd200;
  logic [W:0] r = '0;
  logic v0, v1;
  logic [W-1:0] res0, res1;

  always #(CLK/2) clk = ~clk;

  barrett_modmul #(.W(W)) u0 (
    .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .a(a), .b(b), .m(m), .r_in(r),
    .out_valid(v0), .result(res0));

  // constant modulus at the bottom of the range; ports m/r_in fed junk
  barrett_modmul #(.W(W), .CONST_MOD(1'b1), .MOD_VAL(128)) u1 (
    .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .a(a), .b(b), .m(8'h05), .r_in(9'h000),
    .out_valid(v1), .result(res1));

  typedef struct { int e; bit chk; } item_t;
  item_t q0[$];
  item_t q1[$];
  int total = 0, bad = 0;
  logic en_seen = 1'b0;
  string tag = "R1";

  function automatic int recip(input int mm);
    int v;
    v = (1 << (2*W)) / mm;
    return (v > 511) ? 511 : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input int ia, input int ib, input int im);
    item_t it;
    @(negedge clk);
    a = W'(ia); b = W'(ib); m = W'(im); r = (W+1)'(recip(im));
    in_valid = 1'b1; en = 1'b1;
    it.e = (ia * ib) % im; it.chk = 1'b1; q0.push_back(it);
    it.e = (ia * ib) % 128; it.chk = (ia < 128) && (ib < 128); q1.push_back(it);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; en = 1'b1;
    repeat (n) @(posedge clk);
  endtask

  always @(posedge clk) en_seen <= rst ? 1'b0 : en;

  // monitor / scoreboard
  always @(negedge clk) begin
    item_t it;
    if (!rst && en_seen) begin
      if (v0) begin
        if (q0.size() == 0) check(1'b0, "R3 u0 unexpected valid", 1, 0);
        else begin
          it = q0.pop_front();
          check(res0 == W'(it.e), tag, int'(res0), it.e);
        end
      end
      if (v1) begin
        if (q1.size() == 0) check(1'b0, "R3 u1 unexpected valid", 1, 0);
        else begin
          it = q1.pop_front();
          if (it.chk) check(res1 == W'(it.e), "R6 const modulus", int'(res1), it.e);
        end
      end
    end
  end

  initial begin
    #(CLK * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    logic held_v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(v0 == 1'b0 && v1 == 1'b0, "R5 reset valid", int'(v0), 0);
    rst = 1'b0;

    // R3 latency of a single operand set
    issue(7, 9, 200);
    @(negedge clk); in_valid = 1'b0;
    check(v0 == 1'b0, "R3 early+1", int'(v0), 0);
    @(negedge clk); check(v0 == 1'b0, "R3 early+2", int'(v0), 0);
    @(negedge clk); check(v0 == 1'b0, "R3 early+3", int'(v0), 0);
    @(negedge clk); check(v0 == 1'b1, "R3 due", int'(v0), 1);
    idle(4);

    // R8 range edges and operand corners
    tag = "R8 range edges";
    issue(0, 0, 128); issue(127, 127, 128); issue(0, 127, 128);
    issue(254, 254, 255); issue(254, 1, 255); issue(1, 1, 255);
    issue(100, 127, 129); issue(253, 253, 254);
    idle(6);

    // R1 random operands, R7 back to back
    tag = "R1/R7 stream";
    for (int i = 0; i < 300; i++) begin
      int mm, aa, bb;
      mm = 128 + int'($urandom_range(0, 127));
      aa = int'($urandom_range(0, mm - 1));
      bb = int'($urandom_range(0, mm - 1));
      if (i % 3 == 0) begin aa = aa % 128; bb = bb % 128; end
      issue(aa, bb, mm);
    end
    idle(6);

    // R4 stall mid-stream, junk operands offered while stalled
    tag = "R4/R1 around stall";
    issue(12, 34, 211); issue(200, 150, 223); issue(5, 6, 131);
    @(negedge clk);
    en = 1'b0; in_valid = 1'b1; a = 8'd99; b = 8'd77; m = 8'd140; r = 9'd468;
    held = res0; held_v = v0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(res0 == held && v0 == held_v, "R4 stall hold", int'(res0), int'(held));
    end
    idle(8);

    // R6 constant instance with extra values
    tag = "R1/R6 mix";
    for (int i = 0; i < 40; i++)
      issue(int'($urandom_range(0, 127)), int'($urandom_range(0, 127)), 128 + i);
    idle(8);

    check(q0.size() == 0, "R7 u0 drained", q0.size(), 0);
    check(q1.size() == 0, "R7 u1 drained", q1.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule